// File: doc/BRIEF.md
# Shadow-Register Interrupt Controller

This block handles interrupts for a small 32-bit processor core. The core passes each instruction from the custom0 opcode space to it, along with the value of the instruction's source register. The block answers in the same cycle with one of three things: a result for the destination register, a program-counter redirect, or a stall request. Interrupt state is not kept in control/status registers. It lives in four private shadow registers (q0 to q3), an interrupt mask and a sticky pending bitmask.

The core raises `core_boundary` when it is between instructions and can be redirected, and it supplies the address of the instruction that would run next. An interrupt is taken at such a boundary when it is pending, not masked, and no handler is already running. On entry, q0 takes the return address, q1 takes the bits being serviced, and the core is sent to a fixed vector at 0x10. Dedicated commands copy shadow registers to and from general registers, return from a handler, swap the mask, and wait for an interrupt. A fault interrupt that fires while it is masked stops the core for good.

Top module: `irq_shadow_ctrl`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high and `cmd_insn[6:0]` is 0001011. Bits [31:25] select the operation: 0 copies a shadow register out, 1 copies a value in, 2 returns, 3 swaps the mask and 4 waits. Any other value (including 5, the timer) causes no result, no redirect and no state change. Bits [14:12] and [24:20] are ignored.
- R2: Copy-in (op 1) writes `cmd_src` into the shadow register addressed by `cmd_insn[8:7]`, and only when `cmd_insn[11:9]` is zero. Copy-out (op 0) returns the shadow register addressed by `cmd_insn[16:15]` on `res_data`, with `res_valid` high in the same cycle, and only when `cmd_insn[19:17]` is zero. Otherwise the command is ignored.
- R3: After reset the mask is all ones, q0 and q1 read zero, no handler is active, and `halt`, `stall`, `redirect_valid` and `res_valid` are low.
- R4: The mask swap (op 3) returns the old mask as its result. From the next cycle the mask is the low NIRQ bits of `cmd_src`, where a 1 means disabled.
- R5: Each line of `irq_lines` that is high at a clock edge sets its pending bit. The bit stays set, masked or not, until an interrupt entry takes it.
- R6: An entry happens when `core_boundary` is high, no handler is active, the block is not halted, and pending AND NOT mask is nonzero. In that cycle `redirect_valid` goes high with `redirect_pc` = 0x10, and any command presented is ignored. At the next edge q0 takes `core_pc`, q1 takes the unmasked pending bits, and those bits are cleared from pending.
- R7: While a handler is active, no further entry happens until a return.
- R8: A return (op 2) raises `redirect_valid` with `redirect_pc` equal to q0 and ends the active handler from the next cycle.
- R9: The wait command (op 4) holds `stall` high and `res_valid` low while the pending register is zero. Once it is nonzero, `stall` is low, `res_valid` is high, and `res_data` carries the pending bits, masked ones included.
- R10: If fault line FAULT_IRQ (default 1) is high while its mask bit is set, `halt` rises at the next edge and stays high until reset. While halted, `stall` is high and no entry, redirect or command result occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A custom-space instruction is presented |
| cmd_insn | input | 32 | Instruction word of the command |
| cmd_src | input | XLEN | Value of the instruction's source register |
| core_boundary | input | 1 | Core is between instructions and may be redirected |
| core_pc | input | XLEN | Address of the instruction that would run next |
| irq_lines | input | NIRQ | External interrupt request lines |
| res_valid | output | 1 | `res_data` is to be written to the destination register |
| res_data | output | XLEN | Command result |
| redirect_valid | output | 1 | Core must fetch from `redirect_pc` |
| redirect_pc | output | XLEN | Redirect target |
| stall | output | 1 | Core must hold its current instruction |
| halt | output | 1 | Core stopped by a masked fault |

## Verification
The register commands are driven from a table. It mixes normal encodings, encodings whose ignored fields hold junk, unknown operation codes, a foreign major opcode and index fields with stray upper bits. These separate real decoding from matching on a loose pattern. Interrupt entry is tried with a single unmasked bit, and with unmasked and masked bits arriving together. This shows whether q1 and the pending clear cover exactly the unmasked set. Entry is also tried while a handler is active and right after a return, and the wait command is tried with only masked lines. Together these separate the pending bit from the mask and from the handler state. A masked fault line last shows that the halt is sticky and blocks commands and redirects.

// File: rtl/irqsh_pkg.sv
package irqsh_pkg;
    // Major opcode of the custom command space
    localparam logic [6:0] OPC_CUSTOM = 7'b0001011;

    // Operation selectors (instruction bits [31:25])
    localparam logic [6:0] F7_QREAD  = 7'd0;
    localparam logic [6:0] F7_QWRITE = 7'd1;
    localparam logic [6:0] F7_RETURN = 7'd2;
    localparam logic [6:0] F7_MSWAP  = 7'd3;
    localparam logic [6:0] F7_WAIT   = 7'd4;

    localparam int NUM_Q  = 4;
    localparam int QIDX_W = $clog2(NUM_Q);

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_QREAD,
        CMD_QWRITE,
        CMD_RETURN,
        CMD_MSWAP,
        CMD_WAIT
    } cmd_e;
endpackage

// File: rtl/irqsh_decode.sv
module irqsh_decode
    import irqsh_pkg::*;
(
    input  logic              valid,
    input  logic [31:0]       insn,
    output cmd_e              cmd,
    output logic [QIDX_W-1:0] qidx
);
    logic [6:0] sel;
    logic       in_space;
    logic       unused_fields;

    assign sel      = insn[31:25];
    assign in_space = valid && (insn[6:0] == OPC_CUSTOM);
    // funct3 and rs2 carry no meaning for these commands
    assign unused_fields = ^{insn[24:20], insn[14:12]};

    always_comb begin
        cmd  = CMD_NONE;
        qidx = '0;
        if (in_space) begin
            case (sel)
                F7_QREAD: begin
                    if (insn[19:15+QIDX_W] == '0) begin
                        cmd  = CMD_QREAD;
                        qidx = insn[15 +: QIDX_W];
                    end
                end
                F7_QWRITE: begin
                    if (insn[11:7+QIDX_W] == '0) begin
                        cmd  = CMD_QWRITE;
                        qidx = insn[7 +: QIDX_W];
                    end
                end
                F7_RETURN: cmd = CMD_RETURN;
                F7_MSWAP:  cmd = CMD_MSWAP;
                F7_WAIT:   cmd = CMD_WAIT;
                default:   cmd = CMD_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irqsh_select.sv
module irqsh_select #(
    parameter int NIRQ      = 32,
    parameter int FAULT_IRQ = 1
) (
    input  logic [NIRQ-1:0] pend,
    input  logic [NIRQ-1:0] mask,
    input  logic [NIRQ-1:0] lines,
    input  logic            busy,
    input  logic            halted,
    input  logic            boundary,
    output logic            take,
    output logic [NIRQ-1:0] take_bits,
    output logic            fault_hit
);
    assign take_bits = pend & ~mask;
    assign take      = boundary && !busy && !halted && (|take_bits);
    // A fault that is disabled cannot be serviced: stop the core
    assign fault_hit = lines[FAULT_IRQ] && mask[FAULT_IRQ];
endmodule

// File: rtl/irq_shadow_ctrl.sv
module irq_shadow_ctrl
    import irqsh_pkg::*;
#(
    parameter int              XLEN       = 32,
    parameter int              NIRQ       = 32,
    parameter int              FAULT_IRQ  = 1,
    parameter logic [XLEN-1:0] IRQ_VECTOR = 'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [31:0]     cmd_insn,
    input  logic [XLEN-1:0] cmd_src,
    input  logic            core_boundary,
    input  logic [XLEN-1:0] core_pc,
    input  logic [NIRQ-1:0] irq_lines,
    output logic            res_valid,
    output logic [XLEN-1:0] res_data,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic            stall,
    output logic            halt
);
    typedef struct packed {
        logic [NUM_Q-1:0][XLEN-1:0] q;
        logic [NIRQ-1:0]            mask;
        logic [NIRQ-1:0]            pend;
        logic                       busy;
        logic                       halt;
    } state_t;

    state_t st_d, st_q;

    cmd_e              cmd;
    logic [QIDX_W-1:0] qidx;
    logic              take;
    logic [NIRQ-1:0]   take_bits;
    logic              fault_hit;
    logic              wait_block;
    logic              ret_fire;
    logic [XLEN-1:0]   q0_cur, q1_cur;

    irqsh_decode u_decode (
        .valid (cmd_valid),
        .insn  (cmd_insn),
        .cmd   (cmd),
        .qidx  (qidx)
    );

    irqsh_select #(
        .NIRQ      (NIRQ),
        .FAULT_IRQ (FAULT_IRQ)
    ) u_select (
        .pend      (st_q.pend),
        .mask      (st_q.mask),
        .lines     (irq_lines),
        .busy      (st_q.busy),
        .halted    (st_q.halt),
        .boundary  (core_boundary),
        .take      (take),
        .take_bits (take_bits),
        .fault_hit (fault_hit)
    );

    always_comb begin
        st_d           = st_q;
        res_valid      = 1'b0;
        res_data       = '0;
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        wait_block     = 1'b0;
        ret_fire       = 1'b0;

        st_d.pend = st_q.pend | irq_lines;
        st_d.halt = st_q.halt | fault_hit;

        if (take) begin
            // Entry wins over any command presented at the same boundary
            st_d.pend      = (st_q.pend & ~take_bits) | irq_lines;
            st_d.q[0]      = core_pc;
            st_d.q[1]      = XLEN'(take_bits);
            st_d.busy      = 1'b1;
            redirect_valid = 1'b1;
            redirect_pc    = IRQ_VECTOR;
        end else if (!st_q.halt) begin
            case (cmd)
                CMD_QREAD: begin
                    res_valid = 1'b1;
                    res_data  = st_q.q[qidx];
                end
                CMD_QWRITE: begin
                    st_d.q[qidx] = cmd_src;
                end
                CMD_RETURN: begin
                    ret_fire       = 1'b1;
                    redirect_valid = 1'b1;
                    redirect_pc    = st_q.q[0];
                    st_d.busy      = 1'b0;
                end
                CMD_MSWAP: begin
                    res_valid = 1'b1;
                    res_data  = XLEN'(st_q.mask);
                    st_d.mask = cmd_src[NIRQ-1:0];
                end
                CMD_WAIT: begin
                    if (st_q.pend == '0) begin
                        wait_block = 1'b1;
                    end else begin
                        res_valid = 1'b1;
                        res_data  = XLEN'(st_q.pend);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.q    <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.busy <= 1'b0;
            st_q.halt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stall  = st_q.halt | wait_block;
    assign halt   = st_q.halt;
    assign q0_cur = st_q.q[0];
    assign q1_cur = st_q.q[1];
endmodule

// File: rtl/irqsh_checker.sv
module irqsh_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            take,
    input logic            ret_fire,
    input logic            busy,
    input logic            halt,
    input logic            stall,
    input logic            res_valid,
    input logic            redirect_valid,
    input logic [XLEN-1:0] core_pc,
    input logic [XLEN-1:0] q0,
    input logic [XLEN-1:0] q1
);
    p_entry_saves_pc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (q0 == $past(core_pc)));

    p_entry_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (q1 != '0));

    p_entry_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

    p_no_nest_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !take);

    p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> !busy);

    p_wait_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !halt) |-> !res_valid);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (stall && !redirect_valid && !res_valid));
endmodule

bind irq_shadow_ctrl irqsh_checker #(.XLEN(XLEN)) u_irqsh_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take),
    .ret_fire       (ret_fire),
    .busy           (st_q.busy),
    .halt           (halt),
    .stall          (stall),
    .res_valid      (res_valid),
    .redirect_valid (redirect_valid),
    .core_pc        (core_pc),
    .q0             (q0_cur),
    .q1             (q1_cur)
);

// File: tb/irq_shadow_ctrl_bench.sv
module irq_shadow_ctrl_bench;
    localparam int XLEN = 32;
    localparam int NIRQ = 32;

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1f, input logic [2:0] f3,
                                        input logic [4:0] rd);
        return {f7, rs2, rs1f, f3, rd, 7'b0001011};
    endfunction

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [31:0]     cmd_insn = '0;
    logic [XLEN-1:0] cmd_src = '0;
    logic            core_boundary = 1'b0;
    logic [XLEN-1:0] core_pc = '0;
    logic [NIRQ-1:0] irq_lines = '0;
    logic            res_valid, redirect_valid, stall, halt;
    logic [XLEN-1:0] res_data, redirect_pc;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk; // 4 ns period

    irq_shadow_ctrl u_irq_shadow_ctrl (
        .clk, .rst_n, .cmd_valid, .cmd_insn, .cmd_src, .core_boundary, .core_pc,
        .irq_lines, .res_valid, .res_data, .redirect_valid, .redirect_pc, .stall, .halt
    );

    localparam int NV = 15;
    localparam logic [31:0] TV_INSN [NV] = '{
        enc(7'd1, 5'd0, 5'd0, 3'd0, 5'd2),               // copy-in q2
        enc(7'd1, 5'd31, 5'd0, 3'd7, 5'd3),              // copy-in q3, junk fields
        enc(7'd0, 5'd0, 5'd2, 3'd0, 5'd0),               // copy-out q2
        enc(7'd0, 5'd9, 5'd3, 3'd5, 5'd0),               // copy-out q3, junk fields
        enc(7'd3, 5'd0, 5'd0, 3'd0, 5'd1),               // mask swap
        enc(7'd3, 5'd0, 5'd0, 3'd0, 5'd1),               // mask swap
        enc(7'd1, 5'd0, 5'd0, 3'd0, 5'd0),               // copy-in q0
        enc(7'd0, 5'd0, 5'd0, 3'd0, 5'd0),               // copy-out q0
        enc(7'd5, 5'd0, 5'd2, 3'd0, 5'd1),               // timer code: not handled
        enc(7'h10, 5'd0, 5'd2, 3'd0, 5'd1),              // unknown code
        enc(7'd0, 5'd0, 5'b00110, 3'd0, 5'd0),           // copy-out, stray index bit
        enc(7'd1, 5'd0, 5'd0, 3'd0, 5'b01001),           // copy-in, stray index bit
        {7'd1, 5'd0, 5'd0, 3'd0, 5'd1, 7'b0110011},      // foreign major opcode
        enc(7'd0, 5'd0, 5'd1, 3'd0, 5'd0),               // copy-out q1
        enc(7'd3, 5'd0, 5'd0, 3'd0, 5'd1)                // mask swap
    };
    localparam logic [31:0] TV_SRC [NV] = '{
        32'hA5A5_0001, 32'h1234_5678, 32'h0, 32'h0, 32'h0000_00F0, 32'hFFFF_FF0F,
        32'h0000_0100, 32'h0, 32'h7, 32'h7, 32'h0, 32'h0000_DEAD, 32'h0000_BEEF,
        32'h0, 32'hFFFF_FFFF
    };
    localparam logic TV_VLD [NV] = '{0, 0, 1, 1, 1, 1, 0, 1, 0, 0, 0, 0, 0, 1, 1};
    localparam logic [31:0] TV_RES [NV] = '{
        32'h0, 32'h0, 32'hA5A5_0001, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_00F0,
        32'h0, 32'h0000_0100, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FF0F
    };

    localparam logic [31:0] I_WAIT = enc(7'd4, 5'd0, 5'd0, 3'd0, 5'd1);
    localparam logic [31:0] I_RET  = enc(7'd2, 5'd0, 5'd0, 3'd0, 5'd0);
    localparam logic [31:0] I_MASK = enc(7'd3, 5'd0, 5'd2, 3'd0, 5'd1);

    function automatic logic [31:0] qrd(input int i);
        return enc(7'd0, 5'd0, 5'(i), 3'd0, 5'd0);
    endfunction
    function automatic logic [31:0] qwr(input int i);
        return enc(7'd1, 5'd0, 5'd0, 3'd0, 5'(i));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] insn, input logic [31:0] src,
                         input logic bnd, input logic [31:0] pc, input logic [31:0] lines);
        @(posedge clk);
        #1;
        cmd_valid     = v;
        cmd_insn      = insn;
        cmd_src       = src;
        core_boundary = bnd;
        core_pc       = pc;
        irq_lines     = lines;
        @(negedge clk);
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R3 halt after reset", 32'(halt), 32'h0);
        chk("R3 stall after reset", 32'(stall), 32'h0);
        chk("R3 redirect after reset", 32'(redirect_valid), 32'h0);
        chk("R3 result after reset", 32'(res_valid), 32'h0);

        // Table of register commands (R1, R2, R4; first swap reads reset mask R3)
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, TV_INSN[i], TV_SRC[i], 1'b0, 32'h0, 32'h0);
            chk($sformatf("R1/R2/R4 vector %0d valid", i), 32'(res_valid), 32'(TV_VLD[i]));
            if (TV_VLD[i]) chk($sformatf("R2/R4 vector %0d data", i), res_data, TV_RES[i]);
            chk($sformatf("R1 vector %0d no redirect", i), 32'(redirect_valid), 32'h0);
        end

        // R9 / R5: wait with nothing pending, then a masked line
        drive(1'b1, I_WAIT, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R9 wait stalls", 32'(stall), 32'h1);
        chk("R9 wait no result", 32'(res_valid), 32'h0);
        drive(1'b1, I_WAIT, 32'h0, 1'b0, 32'h0, 32'h10);
        chk("R5 pending not seen before edge", 32'(stall), 32'h1);
        drive(1'b1, I_WAIT, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R9 wait released", 32'(stall), 32'h0);
        chk("R9 wait result valid", 32'(res_valid), 32'h1);
        chk("R5 masked bit pending", res_data, 32'h10);

        // R6: unmask bit 4, then take at a boundary with a command present
        drive(1'b1, I_MASK, 32'hFFFF_FFEF, 1'b0, 32'h0, 32'h0);
        chk("R4 swap returns old mask", res_data, 32'hFFFF_FFFF);
        drive(1'b1, qwr(2), 32'h0000_0BAD, 1'b1, 32'h240, 32'h0);
        chk("R6 entry redirect", 32'(redirect_valid), 32'h1);
        chk("R6 entry vector", redirect_pc, 32'h10);
        drive(1'b1, qrd(0), 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R6 q0 return address", res_data, 32'h240);
        drive(1'b1, qrd(1), 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R6 q1 cause", res_data, 32'h10);
        drive(1'b1, qrd(2), 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R6 command at entry ignored", res_data, 32'hA5A5_0001);
        drive(1'b1, I_WAIT, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R6 taken bit cleared", 32'(stall), 32'h1);

        // R7: no nesting
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h10);
        drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h300, 32'h0);
        chk("R7 no entry in handler", 32'(redirect_valid), 32'h0);

        // R8: return, then re-entry on the still-pending bit
        drive(1'b1, qwr(0), 32'h388, 1'b0, 32'h0, 32'h0);
        drive(1'b1, I_RET, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R8 return redirect", 32'(redirect_valid), 32'h1);
        chk("R8 return target", redirect_pc, 32'h388);
        drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h388, 32'h0);
        chk("R8 entry allowed after return", redirect_pc, 32'h10);
        drive(1'b1, I_RET, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R8 second return target", redirect_pc, 32'h388);

        // R6 / R5: mixed masked and unmasked lines
        drive(1'b1, I_MASK, 32'hFFFF_FEEF, 1'b0, 32'h0, 32'h0);
        chk("R4 swap old mask", res_data, 32'hFFFF_FFEF);
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h118);
        drive(1'b0, 32'h0, 32'h0, 1'b1, 32'h400, 32'h0);
        chk("R6 entry mixed", redirect_pc, 32'h10);
        drive(1'b1, qrd(1), 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R6 q1 only unmasked bits", res_data, 32'h110);
        drive(1'b1, I_WAIT, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R5 masked bit left pending", res_data, 32'h8);
        drive(1'b1, I_RET, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R8 return to saved pc", redirect_pc, 32'h400);

        // R10: masked fault line
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h2);
        chk("R10 halt registered", 32'(halt), 32'h0);
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R10 halt raised", 32'(halt), 32'h1);
        chk("R10 stall while halted", 32'(stall), 32'h1);
        drive(1'b1, I_RET, 32'h0, 1'b1, 32'h500, 32'h0);
        chk("R10 no redirect halted", 32'(redirect_valid), 32'h0);
        drive(1'b1, qrd(0), 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R10 no result halted", 32'(res_valid), 32'h0);
        chk("R10 halt sticky", 32'(halt), 32'h1);

        // R3: reset clears halt and restores defaults
        @(posedge clk);
        #1 rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R3 halt cleared by reset", 32'(halt), 32'h0);
        chk("R3 stall cleared by reset", 32'(stall), 32'h0);
        drive(1'b1, I_MASK, 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R3 mask all ones", res_data, 32'hFFFF_FFFF);
        drive(1'b1, qrd(0), 32'h0, 1'b0, 32'h0, 32'h0);
        chk("R3 q0 zero", res_data, 32'h0);
        drive(1'b0, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule